// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. It keeps three byte-wide registers: pending requests, levels currently in service, and a per-line mask. A resolver picks the highest-priority unmasked request and decides whether it may interrupt the level being serviced. When the processor pulses the acknowledge strobe, the winning request moves from pending to in-service, and a call address is formed from a programmed base byte plus the level number times a 4- or 8-byte spacing.

Software drives the block through a two-address byte port. At the odd address it writes and reads the mask, and once after every initialization it writes the vector base. At the even address it writes command bytes: initialization, end-of-interrupt in specific and non-specific forms, priority rotation, read selection, polling, and a special mask mode that lets lower levels through while a higher one is being serviced. Priority is circular: a bottom pointer names the lowest-priority level, and the level just above it is the highest.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset or after an even-address write with bit 4 set (initialization), the mask and the in-service set are all zero, IR0 has the highest and IR7 the lowest priority, special mask mode is off, even-address reads return the request set, and int_out is low. Reset also clears the request set, rdata and vec_addr.
- R2: An odd-address write that is not the first after initialization loads the mask (bit i for line i, 1 blocks). An odd-address read returns the mask in rdata one cycle later. A masked request never drives int_out.
- R3: int_out goes high one cycle after an unmasked pending request exists whose rotated priority is above every in-service level. While int_ack is high and such a request exists, its request bit is cleared and its in-service bit is set.
- R4: The first odd-address write after initialization loads the vector base. On a granted acknowledge, vec_addr becomes base + level*8, or base + level*4 when bit 2 of the initialization byte was 1, one cycle later.
- R5: Command byte 0x20 at the even address clears the highest-priority in-service bit.
- R6: Command byte 0x60|L clears in-service bit L only.
- R7: Command byte 0xA0 clears the highest-priority in-service bit and makes that level the lowest priority.
- R8: Command byte 0xE0|L clears in-service bit L and makes L the lowest priority; 0xC0|L makes L the lowest priority and leaves the in-service set alone.
- R9: Command byte 0x0A selects the request set and 0x0B the in-service set for even-address reads; the choice persists across any number of reads.
- R10: A command byte with bits 4..3 = 01 and bit 2 set (0x0C) makes the next even-address read return 0x80|L, with L the level that would be granted, or 0x00 if none; later reads return the selected register again.
- R11: Command byte 0x68 enters and 0x48 leaves special mask mode; in that mode any unmasked pending level that is not itself in service raises int_out, regardless of higher levels in service.
- R12: A high irq_in bit sets its request bit on the next clock; the bit stays set until granted, and stays set through a grant while the input is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command/status address, 1 = mask/base address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, registered one cycle after rd_en |
| irq_in | input | 8 | Interrupt request lines, active high |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| int_out | output | 1 | Interrupt output, registered |
| vec_addr | output | 8 | Call address of the last granted level |

## Verification
Requests are applied as single pulses to two lines at once, as a held line, and as a higher line arriving while a lower one is in service, which tells fully nested blocking apart from special mask mode and from a wrongly ordered scan. Rotation is tried by moving the bottom pointer with each rotating command and then offering a pair of lines whose winner differs between fixed and rotated priority. Readback, polling and both vector spacings are compared against a behavioural model that scans levels in priority order and stops at the first in-service level.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LW = 3;

  typedef enum logic {SEL_IRR = 1'b0, SEL_ISR = 1'b1} rd_sel_e;

  typedef struct packed {
    logic              init;
    logic              spc4;
    logic              eoi_top;
    logic              eoi_lvl;
    logic              rot_top;
    logic              set_bot;
    logic              smm_on;
    logic              smm_off;
    logic              poll;
    logic              sel_wr;
    logic              sel_isr;
    logic [PIC_LW-1:0] lvl;
  } pic_cmd_t;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          we,
  input  logic [DW-1:0] d,
  output pic_cmd_t      cmd
);
  always_comb begin
    cmd = '0;
    if (we) begin
      if (d[4]) begin
        cmd.init = 1'b1;
        cmd.spc4 = d[2];
      end else if (!d[3]) begin
        cmd.lvl = d[PIC_LW-1:0];
        case (d[7:5])
          3'b001: cmd.eoi_top = 1'b1;
          3'b011: cmd.eoi_lvl = 1'b1;
          3'b101: begin cmd.eoi_top = 1'b1; cmd.rot_top = 1'b1; end
          3'b111: begin cmd.eoi_lvl = 1'b1; cmd.set_bot = 1'b1; end
          3'b110: cmd.set_bot = 1'b1;
          default: ;
        endcase
      end else begin
        cmd.smm_on  = (d[6:5] == 2'b11);
        cmd.smm_off = (d[6:5] == 2'b10);
        cmd.poll    = d[2];
        cmd.sel_wr  = d[1];
        cmd.sel_isr = d[0];
      end
    end
  end
endmodule

// File: rtl/pic_rot_find.sv
module pic_rot_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] bottom,
  output logic          valid,
  output logic [LW-1:0] idx,
  output logic [LW-1:0] rank
);
  logic [LW-1:0] pos;

  // Scan from lowest to highest priority so the last hit is the winner.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    pos   = '0;
    for (int k = N; k >= 1; k--) begin
      pos = bottom + LW'(k);
      if (vec[pos]) begin
        valid = 1'b1;
        idx   = pos;
      end
    end
    rank = idx - bottom - LW'(1);
  end

  always_comb begin
    if (valid) a_r3_pick_is_set: assert (vec[idx]);
    if (!valid) a_r3_none_means_empty: assert (vec == '0);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N_LINES-1:0] irq_in,
  input  logic          int_ack,
  output logic          int_out,
  output logic [DW-1:0] vec_addr
);
  localparam int LW = $clog2(N_LINES);

  logic [N_LINES-1:0] irr_q, isr_q, mask_q, irr_n, isr_n, req_eff;
  logic [LW-1:0]      bot_q, bot_n;
  logic               smm_q, poll_q, sp4_q, expb_q;
  rd_sel_e            sel_q;
  logic [DW-1:0]      base_q, vec_off, poll_word;
  pic_cmd_t           cmd;

  logic          r_v, s_v, win_ok, ack_do;
  logic [LW-1:0] r_idx, r_rank, s_idx, s_rank;
  logic [LW-1:0] cmd_lvl;

  pic_cmd_decode #(.DW(DW)) u_dec (.we(wr_en & ~addr), .d(wdata), .cmd(cmd));

  assign cmd_lvl = LW'(cmd.lvl);
  assign req_eff = (irr_q & ~mask_q) & (smm_q ? ~isr_q : {N_LINES{1'b1}});

  pic_rot_find #(.N(N_LINES), .LW(LW)) u_req (
    .vec(req_eff), .bottom(bot_q), .valid(r_v), .idx(r_idx), .rank(r_rank));
  pic_rot_find #(.N(N_LINES), .LW(LW)) u_isr (
    .vec(isr_q), .bottom(bot_q), .valid(s_v), .idx(s_idx), .rank(s_rank));

  assign win_ok  = r_v && (smm_q || !s_v || (r_rank < s_rank));
  assign ack_do  = int_ack && win_ok;
  assign vec_off = sp4_q ? (DW'(r_idx) << 2) : (DW'(r_idx) << 3);

  always_comb begin
    poll_word = '0;
    if (win_ok) begin
      poll_word[DW-1]   = 1'b1;
      poll_word[LW-1:0] = r_idx;
    end
  end

  always_comb begin
    isr_n = isr_q;
    if (cmd.eoi_top && s_v) isr_n[s_idx] = 1'b0;
    if (cmd.eoi_lvl) isr_n[cmd_lvl] = 1'b0;
    if (ack_do) isr_n[r_idx] = 1'b1;
    if (cmd.init) isr_n = '0;

    irr_n = irr_q;
    if (ack_do) irr_n[r_idx] = 1'b0;
    irr_n = irr_n | irq_in;

    bot_n = bot_q;
    if (cmd.rot_top && s_v) bot_n = s_idx;
    if (cmd.set_bot) bot_n = cmd_lvl;
    if (cmd.init) bot_n = LW'(N_LINES - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q    <= '0;
      isr_q    <= '0;
      mask_q   <= '0;
      bot_q    <= LW'(N_LINES - 1);
      smm_q    <= 1'b0;
      poll_q   <= 1'b0;
      sp4_q    <= 1'b0;
      expb_q   <= 1'b0;
      sel_q    <= SEL_IRR;
      base_q   <= '0;
      int_out  <= 1'b0;
      vec_addr <= '0;
      rdata    <= '0;
    end else begin
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      bot_q   <= bot_n;
      int_out <= win_ok;
      if (ack_do) vec_addr <= base_q + vec_off;

      if (wr_en && addr) begin
        if (expb_q) begin
          base_q <= wdata;
          expb_q <= 1'b0;
        end else begin
          mask_q <= wdata[N_LINES-1:0];
        end
      end

      if (cmd.init) begin
        mask_q <= '0;
        expb_q <= 1'b1;
        sp4_q  <= cmd.spc4;
        smm_q  <= 1'b0;
        sel_q  <= SEL_IRR;
        poll_q <= 1'b0;
      end
      if (cmd.smm_on)  smm_q <= 1'b1;
      if (cmd.smm_off) smm_q <= 1'b0;
      if (cmd.sel_wr)  sel_q <= cmd.sel_isr ? SEL_ISR : SEL_IRR;
      if (cmd.poll)    poll_q <= 1'b1;

      if (rd_en) begin
        if (addr) begin
          rdata <= DW'(mask_q);
        end else if (poll_q) begin
          rdata  <= poll_word;
          poll_q <= 1'b0;
        end else begin
          rdata <= (sel_q == SEL_ISR) ? DW'(isr_q) : DW'(irr_q);
        end
      end
    end
  end

  a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && !expb_q) |=> (mask_q == $past(wdata[N_LINES-1:0])));

  a_r1_init_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4] && !int_ack) |=> (isr_q == '0 && mask_q == '0));

  a_r6_spec_eoi: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[7:3] == 5'b01100 && !int_ack)
      |=> !isr_q[$past(wdata[LW-1:0])]);

  a_r3_ack_moves: assert property (@(posedge clk) disable iff (rst)
    (int_ack && win_ok) |=> isr_q[$past(r_idx)]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, int_ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_addr;
  logic       int_out;

  int    n_chk = 0, n_bad = 0;
  bit    cmp_on = 1'b0;
  string phase = "R1 reset";

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_ack(int_ack),
    .int_out(int_out), .vec_addr(vec_addr));

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_irr, m_isr, m_mask, m_base, m_rdata, m_vec;
  int         m_bot;
  bit         m_smm, m_poll, m_sp4, m_expb, m_selisr, m_int;

  always @(posedge clk) begin
    int  win, top, l, cmdv, lv;
    bit  wok, tv, done;
    logic [7:0] n_isr;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_base = 0; m_rdata = 0; m_vec = 0;
      m_bot = 7; m_smm = 0; m_poll = 0; m_sp4 = 0; m_expb = 0;
      m_selisr = 0; m_int = 0;
    end else begin
      wok = 0; win = 0; done = 0;
      for (int k = 1; k <= 8; k++) begin
        l = (m_bot + k) % 8;
        if (!done) begin
          if (!m_smm && m_isr[l]) done = 1;
          else if (m_irr[l] && !m_mask[l] && !(m_smm && m_isr[l])) begin
            wok = 1; win = l; done = 1;
          end
        end
      end
      tv = 0; top = 0;
      for (int k = 8; k >= 1; k--) begin
        l = (m_bot + k) % 8;
        if (m_isr[l]) begin tv = 1; top = l; end
      end
      if (rd_en) begin
        if (addr) m_rdata = m_mask;
        else if (m_poll) begin m_rdata = wok ? (8'h80 | 8'(win)) : 8'h00; m_poll = 0; end
        else m_rdata = m_selisr ? m_isr : m_irr;
      end
      n_isr = m_isr;
      if (int_ack && wok) begin
        m_vec = m_base + 8'(win * (m_sp4 ? 4 : 8));
        m_irr[win] = 1'b0;
      end
      if (wr_en && addr) begin
        if (m_expb) begin m_base = wdata; m_expb = 0; end
        else m_mask = wdata;
      end
      if (wr_en && !addr) begin
        lv = wdata[2:0];
        if (wdata[4]) begin
          n_isr = 0; m_mask = 0; m_bot = 7; m_smm = 0; m_selisr = 0;
          m_poll = 0; m_sp4 = wdata[2]; m_expb = 1;
        end else if (!wdata[3]) begin
          cmdv = wdata[7:5];
          if ((cmdv == 1 || cmdv == 5) && tv) n_isr[top] = 1'b0;
          if (cmdv == 5 && tv) m_bot = top;
          if (cmdv == 3 || cmdv == 7) n_isr[lv] = 1'b0;
          if (cmdv == 7 || cmdv == 6) m_bot = lv;
        end else begin
          if (wdata[6:5] == 2'b11) m_smm = 1;
          if (wdata[6:5] == 2'b10) m_smm = 0;
          if (wdata[2]) m_poll = 1;
          if (wdata[1]) m_selisr = wdata[0];
        end
      end
      if (int_ack && wok) n_isr[win] = 1'b1;
      m_isr = n_isr;
      m_irr = m_irr | irq_in;
      m_int = wok;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check({phase, " int_out"}, 32'(int_out), 32'(m_int));
      check({phase, " rdata"}, 32'(rdata), 32'(m_rdata));
      check({phase, " vec_addr"}, 32'(vec_addr), 32'(m_vec));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask
  task automatic pulse(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    phase = "R1 reset state";
    check("R1 int_out after reset", 32'(int_out), 0);
    rd(1'b1); check("R1 mask after reset", 32'(rdata), 0);
    rd(1'b0); check("R1 request set after reset", 32'(rdata), 0);

    phase = "R4 init spacing 8";
    wr(1'b0, 8'h10); wr(1'b1, 8'h40);

    phase = "R2 mask readback";
    wr(1'b1, 8'h5A); rd(1'b1); check("R2 mask readback", 32'(rdata), 32'h5A);
    wr(1'b1, 8'h00);

    phase = "R12 held request";
    irq_in = 8'h02; idle(2);
    check("R12 int_out for held line", 32'(int_out), 1);
    ack(); check("R4 vector line1", 32'(vec_addr), 32'h48);
    wr(1'b0, 8'h0A); rd(1'b0); check("R12 request kept while held", 32'(rdata), 32'h02);
    irq_in = 8'h00;
    phase = "R5 EOI with held request";
    wr(1'b0, 8'h20); idle(2); check("R5 int_out after EOI", 32'(int_out), 1);
    ack(); wr(1'b0, 8'h20); rd(1'b0); check("R12 request cleared by grant", 32'(rdata), 0);

    phase = "R3 nested pair";
    pulse(8'h24); idle(2);
    rd(1'b0); check("R3 request set", 32'(rdata), 32'h24);
    check("R3 int_out", 32'(int_out), 1);
    ack(); check("R3 grant line2 vector", 32'(vec_addr), 32'h50);
    idle(2); check("R3 lower line blocked", 32'(int_out), 0);

    phase = "R9 read select";
    wr(1'b0, 8'h0B); rd(1'b0); check("R9 in-service read", 32'(rdata), 32'h04);
    rd(1'b0); check("R9 selection persists", 32'(rdata), 32'h04);

    phase = "R11 special mask";
    wr(1'b0, 8'h68); idle(2); check("R11 lower line enabled", 32'(int_out), 1);
    wr(1'b0, 8'h48); idle(2); check("R11 mode left", 32'(int_out), 0);

    phase = "R5 nonspecific EOI";
    wr(1'b0, 8'h20); rd(1'b0); check("R5 top in-service cleared", 32'(rdata), 0);
    idle(1); check("R5 line5 now raises", 32'(int_out), 1);
    ack(); check("R4 vector line5", 32'(vec_addr), 32'h68);
    rd(1'b0); check("R3 in-service after grant", 32'(rdata), 32'h20);

    phase = "R10 poll";
    pulse(8'h01); idle(1);
    wr(1'b0, 8'h0C); rd(1'b0); check("R10 poll word", 32'(rdata), 32'h80);
    rd(1'b0); check("R10 back to selected register", 32'(rdata), 32'h20);

    phase = "R6 specific EOI";
    ack(); check("R6 grant line0", 32'(vec_addr), 32'h40);
    wr(1'b0, 8'h65); rd(1'b0); check("R6 only line5 cleared", 32'(rdata), 32'h01);

    phase = "R7 rotate on EOI";
    wr(1'b0, 8'hA0); rd(1'b0); check("R7 line0 cleared", 32'(rdata), 0);

    phase = "R8 rotation";
    pulse(8'h81); idle(2);
    ack(); check("R7 line7 wins after rotation", 32'(vec_addr), 32'h78);
    wr(1'b0, 8'hE7); rd(1'b0); check("R8 specific rotate cleared", 32'(rdata), 0);
    ack(); check("R8 line0 top again", 32'(vec_addr), 32'h40);
    wr(1'b0, 8'hC3); rd(1'b0); check("R8 set bottom keeps in-service", 32'(rdata), 32'h01);
    wr(1'b0, 8'h20);
    pulse(8'h18); idle(2);
    ack(); check("R8 line4 beats line3", 32'(vec_addr), 32'h60);
    wr(1'b0, 8'h20); idle(1);
    ack(); check("R8 line3 next", 32'(vec_addr), 32'h58);
    wr(1'b0, 8'h20);

    phase = "R1 reinit spacing 4";
    wr(1'b1, 8'hF0); wr(1'b0, 8'h14);
    rd(1'b1); check("R1 init clears mask", 32'(rdata), 0);
    wr(1'b0, 8'h0B); rd(1'b0); check("R1 init clears in-service", 32'(rdata), 0);
    wr(1'b1, 8'h80); wr(1'b1, 8'h40);
    phase = "R2 masked line";
    pulse(8'h40); idle(2); check("R2 masked line silent", 32'(int_out), 0);
    wr(1'b1, 8'h00); idle(2); check("R2 unmasked line raises", 32'(int_out), 1);
    phase = "R4 spacing 4";
    ack(); check("R4 vector line6 spacing 4", 32'(vec_addr), 32'h98);
    idle(3);

    summary();
    $finish;
  end
endmodule